// File: doc/BRIEF.md
# Logic Self-Test Sequencer

This block wraps a small combinational circuit with everything needed to test it on chip from one control pin. A pulse on `start` begins a run. A maximal-length shift-register generator then drives the circuit's inputs with a repeatable pseudo-random sequence, one pattern per clock, for a fixed number of cycles. Each output word is folded into a multiple-input signature register rather than kept, so the whole response ends up in one word. At the end that word is compared with a fault-free value fixed at build time, and the block raises `done` together with exactly one of `pass` or `fail`.

The pattern count, the fault-free signature, the seeds and the feedback taps are all parameters. The example circuit can be built with a stuck-at fault on any one output bit, which is how detection is shown. A passing verdict is not proof of a fault-free circuit, because a faulty response stream can compact to the same signature (aliasing). Such a false pass is possible but unlikely.

Top module: `lbist_ctrl`

## Requirements
- R1: While reset is held high, and after it is released, `done`, `pass` and `fail` are low and the sequencer is idle.
- R2: A `start` sampled high while idle is accepted. On that edge the generator loads its seed (default 0x01), the signature register loads its seed (default 0xFF), and `done`, `pass` and `fail` go low.
- R3: `start` has no effect unless the sequencer is idle. A pulse during a run changes neither the run's length nor its verdict.
- R4: The generator shifts toward the MSB. Its new LSB is the XOR of the state bits selected by the taps (default 0xB8, polynomial x^8+x^6+x^5+x^4+1). The state is never zero during a run.
- R5: Exactly `N_PATTERNS` patterns are applied, one per cycle, starting with the seed. `done` rises `N_PATTERNS`+2 clock edges after the edge that accepts `start`.
- R6: Each run cycle the signature becomes {sig[W-2:0], XOR of sig bits selected by the taps (default 0xB8)} XOR the circuit's output word.
- R7: The example circuit computes output bit i from inputs j=(i+1) mod W and k=(i+3) mod W. For even i it is (a[i] AND a[j]) XOR a[k]. For odd i it is (a[i] OR a[j]) XOR a[k].
- R8: `pass` is set when the final signature equals `GOLDEN`, and `fail` is set otherwise. Whenever `done` is high, exactly one of them is high.
- R9: `done`, `pass` and `fail` hold their values until the next accepted `start`. A repeated run from the same seeds gives the same verdict.
- R10: `FAULT_MODE`=1 forces output bit `FAULT_BIT` of the circuit to 0, and `FAULT_MODE`=2 forces it to 1. A fault that changes the signature is reported as `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a self-test run when idle |
| done | output | 1 | Run finished; verdict valid |
| pass | output | 1 | Signature matched the fault-free value |
| fail | output | 1 | Signature differed from the fault-free value |

## Verification
Some properties are checked by assertions on every cycle:
- `pass` and `fail` are mutually exclusive, and exactly one is high while `done` is high.
- The seeds are loaded on an accepted start.
- The generator never reaches zero during a run.
- Run and compare states cannot be left early, and `start` cannot disturb them.
- `done` holds until a new start.

Other behaviour only the bench's scenarios can show:
- The signature value itself, checked through the verdict against a fault-free signature the bench computes from its own model of generator, circuit and compactor.
- The exact latency.
- Repeatability across runs.
- Detection of stuck-at-0 and stuck-at-1 faults.
- A failing verdict when the stored signature is wrong.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_COMPARE = 2'd2,
    ST_DONE    = 2'd3
  } st_e;

  // Fault injection selectors for the example circuit
  localparam int FLT_NONE = 0;
  localparam int FLT_SA0  = 1;
  localparam int FLT_SA1  = 2;

endpackage

// File: rtl/lbist_prpg.sv
// Fibonacci pattern generator, shifting toward the MSB.
module lbist_prpg #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] q
);

  logic fb;

  assign fb = ^(q & TAPS);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      q <= SEED;
    end else if (step) begin
      q <= {q[W-2:0], fb};
    end
  end

endmodule

// File: rtl/lbist_misr.sv
// Multiple-input signature register: shift with feedback, then fold in the response.
module lbist_misr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'hFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         capture,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig
);

  logic         fb;
  logic [W-1:0] shifted;

  assign fb      = ^(sig & TAPS);
  assign shifted = {sig[W-2:0], fb};

  always_ff @(posedge clk) begin
    if (rst || load) begin
      sig <= SEED;
    end else if (capture) begin
      sig <= shifted ^ resp;
    end
  end

endmodule

// File: rtl/lbist_cut.sv
// Example combinational circuit under test with optional stuck-at output fault.
module lbist_cut #(
  parameter int IN_W       = 8,
  parameter int OUT_W      = 8,
  parameter int FAULT_MODE = 0,
  parameter int FAULT_BIT  = 0
) (
  input  logic [IN_W-1:0]  a,
  output logic [OUT_W-1:0] y
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    localparam int II = i % IN_W;
    localparam int JJ = (i + 1) % IN_W;
    localparam int KK = (i + 3) % IN_W;
    logic good;

    if ((i % 2) == 0) begin : g_even
      assign good = (a[II] & a[JJ]) ^ a[KK];
    end else begin : g_odd
      assign good = (a[II] | a[JJ]) ^ a[KK];
    end

    if (FAULT_MODE == lbist_pkg::FLT_SA0 && i == FAULT_BIT) begin : g_sa0
      assign y[i] = 1'b0;
    end else if (FAULT_MODE == lbist_pkg::FLT_SA1 && i == FAULT_BIT) begin : g_sa1
      assign y[i] = 1'b1;
    end else begin : g_ok
      assign y[i] = good;
    end
  end

endmodule

// File: rtl/lbist_seq.sv
// Sequencing FSM, pattern counter and signature comparator with registered verdict.
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int              N_PATTERNS = 200,
  parameter int              SIG_W      = 8,
  parameter logic [SIG_W-1:0] GOLDEN    = '0,
  localparam int             CNT_W      = (N_PATTERNS > 1) ? $clog2(N_PATTERNS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SIG_W-1:0] sig,
  output st_e              state,
  output logic [CNT_W-1:0] cnt,
  output logic             load,
  output logic             step,
  output logic             done,
  output logic             pass,
  output logic             fail
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_PATTERNS - 1);

  logic match_q;

  assign load = (state == ST_IDLE) && start;
  assign step = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      match_q <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
            done  <= 1'b0;
            pass  <= 1'b0;
            fail  <= 1'b0;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            state <= ST_COMPARE;
          end
        end
        ST_COMPARE: begin
          match_q <= (sig == GOLDEN);
          state   <= ST_DONE;
        end
        ST_DONE: begin
          done  <= 1'b1;
          pass  <= match_q;
          fail  <= ~match_q;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lbist_ctrl.sv
// Self-test wrapper: pattern generator -> circuit under test -> signature register -> verdict.
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int               PAT_W      = 8,
  parameter logic [PAT_W-1:0] PAT_TAPS   = 8'hB8,
  parameter logic [PAT_W-1:0] PAT_SEED   = 8'h01,
  parameter int               SIG_W      = 8,
  parameter logic [SIG_W-1:0] SIG_TAPS   = 8'hB8,
  parameter logic [SIG_W-1:0] SIG_SEED   = 8'hFF,
  parameter int               N_PATTERNS = 200,
  parameter logic [SIG_W-1:0] GOLDEN     = '0,
  parameter int               FAULT_MODE = 0,
  parameter int               FAULT_BIT  = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done,
  output logic pass,
  output logic fail
);

  localparam int CNT_W = (N_PATTERNS > 1) ? $clog2(N_PATTERNS) : 1;

  st_e              state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load;
  logic             step;
  logic [PAT_W-1:0] pat_q;
  logic [SIG_W-1:0] resp;
  logic [SIG_W-1:0] sig_q;

  lbist_seq #(
    .N_PATTERNS(N_PATTERNS),
    .SIG_W     (SIG_W),
    .GOLDEN    (GOLDEN)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .sig  (sig_q),
    .state(state_q),
    .cnt  (cnt_q),
    .load (load),
    .step (step),
    .done (done),
    .pass (pass),
    .fail (fail)
  );

  lbist_prpg #(
    .W   (PAT_W),
    .TAPS(PAT_TAPS),
    .SEED(PAT_SEED)
  ) u_prpg (
    .clk (clk),
    .rst (rst),
    .load(load),
    .step(step),
    .q   (pat_q)
  );

  lbist_cut #(
    .IN_W      (PAT_W),
    .OUT_W     (SIG_W),
    .FAULT_MODE(FAULT_MODE),
    .FAULT_BIT (FAULT_BIT)
  ) u_cut (
    .a(pat_q),
    .y(resp)
  );

  lbist_misr #(
    .W   (SIG_W),
    .TAPS(SIG_TAPS),
    .SEED(SIG_SEED)
  ) u_misr (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .capture(step),
    .resp   (resp),
    .sig    (sig_q)
  );

endmodule

// File: rtl/lbist_ctrl_chk.sv
// Property checker attached to every lbist_ctrl instance.
module lbist_ctrl_chk
  import lbist_pkg::*;
#(
  parameter int               PAT_W      = 8,
  parameter logic [PAT_W-1:0] PAT_SEED   = 8'h01,
  parameter int               SIG_W      = 8,
  parameter logic [SIG_W-1:0] SIG_SEED   = 8'hFF,
  parameter int               N_PATTERNS = 200,
  localparam int              CNT_W      = (N_PATTERNS > 1) ? $clog2(N_PATTERNS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic             pass,
  input logic             fail,
  input st_e              state,
  input logic [CNT_W-1:0] cnt,
  input logic [PAT_W-1:0] pat,
  input logic [SIG_W-1:0] sig
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_PATTERNS - 1);

  assert_verdict_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  assert_done_has_verdict_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass != fail));

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> (pat == PAT_SEED && sig == SIG_SEED && !done));

  assert_pattern_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (pat != '0));

  assert_run_not_cut_short_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt != LAST) |=> (state == ST_RUN));

  assert_run_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt == LAST) |=> (state == ST_COMPARE));

  assert_compare_to_done_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMPARE) |=> (state == ST_DONE));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !(state == ST_IDLE && start)) |=> (done && $stable(pass)));

endmodule

bind lbist_ctrl lbist_ctrl_chk #(
  .PAT_W     (PAT_W),
  .PAT_SEED  (PAT_SEED),
  .SIG_W     (SIG_W),
  .SIG_SEED  (SIG_SEED),
  .N_PATTERNS(N_PATTERNS)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .start(start),
  .done (done),
  .pass (pass),
  .fail (fail),
  .state(state_q),
  .cnt  (cnt_q),
  .pat  (pat_q),
  .sig  (sig_q)
);

// File: tb/test_lbist_ctrl.sv
`timescale 1ns/1ps
module test_lbist_ctrl;

  localparam int NPAT = 200;

  // Independent model of generator, example circuit and compactor (R4, R6, R7)
  function automatic logic [7:0] cut_model(input logic [7:0] a, input int mode, input int fbit);
    logic [7:0] y;
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) y[i] = (a[i] & a[(i+1)%8]) ^ a[(i+3)%8];
      else            y[i] = (a[i] | a[(i+1)%8]) ^ a[(i+3)%8];
      if (mode == 1 && i == fbit) y[i] = 1'b0;
      if (mode == 2 && i == fbit) y[i] = 1'b1;
    end
    return y;
  endfunction

  function automatic logic [7:0] sig_model(input int mode, input int fbit);
    logic [7:0] p;
    logic [7:0] s;
    p = 8'h01;
    s = 8'hFF;
    for (int n = 0; n < NPAT; n++) begin
      s = {s[6:0], ^(s & 8'hB8)} ^ cut_model(p, mode, fbit);
      p = {p[6:0], ^(p & 8'hB8)};
    end
    return s;
  endfunction

  localparam logic [7:0] GOLD    = sig_model(0, 0);
  localparam logic [7:0] SIG_SA0 = sig_model(1, 0);
  localparam logic [7:0] SIG_SA1 = sig_model(2, 5);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, pass, fail;
  logic done0, pass0, fail0;
  logic done1, pass1, fail1;
  logic doneg, passg, failg;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lbist_ctrl #(.N_PATTERNS(NPAT), .GOLDEN(GOLD)) i_lbist_ctrl (
    .clk(clk), .rst(rst), .start(start), .done(done), .pass(pass), .fail(fail));

  lbist_ctrl #(.N_PATTERNS(NPAT), .GOLDEN(GOLD), .FAULT_MODE(1), .FAULT_BIT(0)) i_lbist_ctrl_sa0 (
    .clk(clk), .rst(rst), .start(start), .done(done0), .pass(pass0), .fail(fail0));

  lbist_ctrl #(.N_PATTERNS(NPAT), .GOLDEN(GOLD), .FAULT_MODE(2), .FAULT_BIT(5)) i_lbist_ctrl_sa1 (
    .clk(clk), .rst(rst), .start(start), .done(done1), .pass(pass1), .fail(fail1));

  lbist_ctrl #(.N_PATTERNS(NPAT), .GOLDEN(GOLD ^ 8'h01)) i_lbist_ctrl_badgold (
    .clk(clk), .rst(rst), .start(start), .done(doneg), .pass(passg), .fail(failg));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulse start, return cycles from accepting edge to done; optionally poke start mid-run.
  task automatic run_once(input int poke_at, output int lat, output bit done_cleared);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    done_cleared = !done && !pass && !fail;
    lat = 0;
    for (int k = 1; k <= NPAT + 50; k++) begin
      if (k == poke_at) start = 1'b1;
      if (k == poke_at + 3) start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (done) begin
        lat = k;
        break;
      end
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !pass && !fail, "R1", "outputs in reset", {done, pass, fail}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!done && !pass && !fail, "R1", "outputs after reset", {done, pass, fail}, 0);
  endtask

  task automatic t_good_run();
    int  lat;
    bit  clr;
    run_once(-10, lat, clr);
    check(lat == NPAT + 2, "R5", "latency to done", lat, NPAT + 2);
    check(pass && !fail, "R8", "fault-free pass (R4 R6 R7 signature)", {pass, fail}, 2);
    check(clr, "R2", "verdict cleared on accept", clr, 1);
  endtask

  task automatic t_hold();
    repeat (25) @(negedge clk);
    check(done && pass && !fail, "R9", "verdict held while idle", {done, pass, fail}, 6);
  endtask

  task automatic t_rerun();
    int lat;
    bit clr;
    run_once(-10, lat, clr);
    check(clr, "R2", "done cleared by new start", clr, 1);
    check(lat == NPAT + 2 && pass && !fail, "R9", "repeat run same verdict", {pass, fail}, 2);
  endtask

  task automatic t_start_ignored();
    int lat;
    bit clr;
    run_once(60, lat, clr);
    check(lat == NPAT + 2, "R3", "latency with start during run", lat, NPAT + 2);
    check(pass && !fail, "R3", "verdict with start during run", {pass, fail}, 2);
  endtask

  task automatic t_faults();
    check(done0 && (fail0 == (SIG_SA0 != GOLD)) && (pass0 != fail0), "R10",
          "stuck-at-0 bit0 verdict", {pass0, fail0}, (SIG_SA0 != GOLD) ? 1 : 2);
    check(fail0 == 1'b1, "R10", "stuck-at-0 detected", fail0, 1);
    check(done1 && (fail1 == (SIG_SA1 != GOLD)) && (pass1 != fail1), "R10",
          "stuck-at-1 bit5 verdict", {pass1, fail1}, (SIG_SA1 != GOLD) ? 1 : 2);
  endtask

  task automatic t_bad_golden();
    check(doneg && failg && !passg, "R8", "wrong stored signature fails", {passg, failg}, 1);
  endtask

  initial begin
    t_reset();
    t_good_run();
    t_hold();
    t_rerun();
    t_start_ignored();
    t_faults();
    t_bad_golden();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule